// File: doc/BRIEF.md
# Serial Front-End Command Link

This block carries short command words from a readout module to front-end boards over one serial wire, clocked by the system clock. The transmitter half takes a command (a code, a trigger tag and, when the command asks for it, a time address into the front-end ring buffer and a readout length) over a valid/ready port. It then drives the command onto the wire one bit per clock, behind a start marker. The receiver half watches a wire that rests high, spots the marker, collects the fields and hands them out with a single-cycle strobe. It also flags frames whose marker is malformed.

Each frame opens with a low bit followed by a high bit. A basic frame holds the code and the tag, giving 12 bits with the default widths. An extended frame appends the address and then the length, giving 23 bits with the defaults. Every field is sent most significant bit first. Both halves share the field-width parameters. The command port follows valid/ready rules. While `in_valid` is high and `in_ready` is low, the sender must hold `in_valid` and every command field steady. A command is taken in any cycle in which both are high. The receiver output has no back-pressure: a strobe that is not used in its own cycle is lost. The receiver's fields stay unchanged until the next strobe.

Top module: `cmd_link`

## Requirements
- R1: After reset, `tx_line` rests at 1, `in_ready` is 1, and `rx_valid` and `rx_frame_err` are 0.
- R2: A basic command (`in_ext`=0) taken at a clock edge produces, starting in the next cycle, these bits on `tx_line`, one per cycle: 0, 1, then the code MSB first, then the tag MSB first. That is 2+CODE_W+TAG_W bits in total.
- R3: An extended command (`in_ext`=1) produces the basic bits followed by the address MSB first and then the length MSB first. That is 2+CODE_W+TAG_W+ADDR_W+LEN_W bits in total.
- R4: `in_ready` is low in every cycle in which a frame bit is on the line. While the sender waits for `in_ready`, it holds `in_valid` and the command fields stable.
- R5: `in_ready` returns high in the cycle right after the last frame bit. A command taken in that cycle starts its marker one cycle later, so back-to-back frames are spaced exactly one idle bit apart.
- R6: For a frame looped from `tx_line` to `rx_line`, `rx_valid` is high for exactly one cycle. That cycle comes a frame length of cycles after the accepting edge. `rx_code`, `rx_tag`, `rx_addr` and `rx_len` equal the sent fields and hold their values between strobes.
- R7: The receiver reads a frame in the mode given by `rx_ext`, sampled when it sees the start bit. In basic mode, `rx_addr` and `rx_len` are reported as 0.
- R8: If the bit after a start bit is 0, the receiver discards the frame, pulses `rx_frame_err` for one cycle with no `rx_valid`, and returns to looking for a start bit. A correct frame that follows is then received normally.
- R9: A line held high produces neither `rx_valid` nor `rx_frame_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one line bit per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Command offered |
| in_ready | output | 1 | Transmitter idle, command taken when valid |
| in_ext | input | 1 | 1 = extended frame with address and length |
| in_code | input | CODE_W | Command code |
| in_tag | input | TAG_W | Trigger tag |
| in_addr | input | ADDR_W | Ring-buffer time address (extended only) |
| in_len | input | LEN_W | Readout length (extended only) |
| tx_line | output | 1 | Serial command line out, idles high |
| rx_line | input | 1 | Serial command line in |
| rx_ext | input | 1 | Receiver frame mode, 1 = extended |
| rx_valid | output | 1 | One-cycle strobe: fields below are new |
| rx_code | output | CODE_W | Received command code |
| rx_tag | output | TAG_W | Received trigger tag |
| rx_addr | output | ADDR_W | Received address, 0 in basic mode |
| rx_len | output | LEN_W | Received length, 0 in basic mode |
| rx_frame_err | output | 1 | One-cycle pulse on a bad marker |

## Verification
The assertions take for granted that a waiting sender keeps `in_valid` and the fields steady until `in_ready`. They also assume that `rx_ext` matches the mode of the frame in flight and changes only while the receiver is between frames. The bench raises `in_valid` together with all fields and keeps them until acceptance. It updates `rx_ext` in the same step as each command, which always happens after the previous frame's last bit has been sampled. Malformed frames are injected directly on `rx_line` only while the transmitter is idle.

// File: rtl/cmd_link_pkg.sv
package cmd_link_pkg;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_MARK = 2'd1,
    RX_BODY = 2'd2
  } rx_state_e;

endpackage

// File: rtl/cmd_link_tx.sv
module cmd_link_tx #(
  parameter int CODE_W = 5,
  parameter int TAG_W  = 5,
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_ext,
  input  logic [CODE_W-1:0] in_code,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LEN_W-1:0]  in_len,
  output logic              tx_line
);

  localparam int FMAX = 2 + CODE_W + TAG_W + ADDR_W + LEN_W;
  localparam int FBAS = 2 + CODE_W + TAG_W;
  localparam int CW   = $clog2(FMAX + 1);
  localparam logic [CW-1:0] LAST_EXT = CW'(FMAX - 1);
  localparam logic [CW-1:0] LAST_BAS = CW'(FBAS - 1);

  logic [FMAX-1:0] sreg;
  logic [FMAX-1:0] frame;
  logic [CW-1:0]   cnt;
  logic            busy;

  // frame is left aligned; a basic frame simply leaves the tail unused
  always_comb begin
    if (in_ext) frame = {2'b01, in_code, in_tag, in_addr, in_len};
    else        frame = {2'b01, in_code, in_tag, {(ADDR_W + LEN_W){1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sreg <= '0;
      cnt  <= '0;
    end else if (!busy) begin
      if (in_valid) begin
        busy <= 1'b1;
        sreg <= frame;
        cnt  <= in_ext ? LAST_EXT : LAST_BAS;
      end
    end else begin
      sreg <= {sreg[FMAX-2:0], 1'b0};
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - CW'(1);
    end
  end

  assign in_ready = !busy;
  assign tx_line  = busy ? sreg[FMAX-1] : 1'b1;

endmodule

// File: rtl/cmd_link_rx.sv
module cmd_link_rx
  import cmd_link_pkg::*;
#(
  parameter int CODE_W = 5,
  parameter int TAG_W  = 5,
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              rx_ext,
  output logic              rx_valid,
  output logic [CODE_W-1:0] rx_code,
  output logic [TAG_W-1:0]  rx_tag,
  output logic [ADDR_W-1:0] rx_addr,
  output logic [LEN_W-1:0]  rx_len,
  output logic              rx_frame_err
);

  localparam int PMAX = CODE_W + TAG_W + ADDR_W + LEN_W;
  localparam int PBAS = CODE_W + TAG_W;
  localparam int CW   = $clog2(PMAX + 1);

  rx_state_e       state;
  logic            ext_q;
  logic [CW-1:0]   cnt;
  logic [PMAX-2:0] sreg;
  logic [PMAX-1:0] nxt;

  assign nxt = {sreg, rx_line};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= RX_IDLE;
      ext_q        <= 1'b0;
      cnt          <= '0;
      sreg         <= '0;
      rx_valid     <= 1'b0;
      rx_frame_err <= 1'b0;
      rx_code      <= '0;
      rx_tag       <= '0;
      rx_addr      <= '0;
      rx_len       <= '0;
    end else begin
      rx_valid     <= 1'b0;
      rx_frame_err <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (!rx_line) begin
            state <= RX_MARK;
            ext_q <= rx_ext;
          end
        end
        RX_MARK: begin
          if (rx_line) begin
            state <= RX_BODY;
            sreg  <= '0;
            cnt   <= ext_q ? CW'(PMAX - 1) : CW'(PBAS - 1);
          end else begin
            state        <= RX_IDLE;
            rx_frame_err <= 1'b1;
          end
        end
        RX_BODY: begin
          sreg <= nxt[PMAX-2:0];
          if (cnt == '0) begin
            state    <= RX_IDLE;
            rx_valid <= 1'b1;
            if (ext_q) begin
              rx_code <= nxt[PMAX-1 -: CODE_W];
              rx_tag  <= nxt[PMAX-CODE_W-1 -: TAG_W];
              rx_addr <= nxt[ADDR_W+LEN_W-1 -: ADDR_W];
              rx_len  <= nxt[LEN_W-1:0];
            end else begin
              rx_code <= nxt[PBAS-1 -: CODE_W];
              rx_tag  <= nxt[TAG_W-1:0];
              rx_addr <= '0;
              rx_len  <= '0;
            end
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cmd_link.sv
module cmd_link #(
  parameter int CODE_W = 5,
  parameter int TAG_W  = 5,
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_ext,
  input  logic [CODE_W-1:0] in_code,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LEN_W-1:0]  in_len,
  output logic              tx_line,
  input  logic              rx_line,
  input  logic              rx_ext,
  output logic              rx_valid,
  output logic [CODE_W-1:0] rx_code,
  output logic [TAG_W-1:0]  rx_tag,
  output logic [ADDR_W-1:0] rx_addr,
  output logic [LEN_W-1:0]  rx_len,
  output logic              rx_frame_err
);

  cmd_link_tx #(
    .CODE_W(CODE_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
  ) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_ready(in_ready),
    .in_ext  (in_ext),
    .in_code (in_code),
    .in_tag  (in_tag),
    .in_addr (in_addr),
    .in_len  (in_len),
    .tx_line (tx_line)
  );

  cmd_link_rx #(
    .CODE_W(CODE_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
  ) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_line     (rx_line),
    .rx_ext      (rx_ext),
    .rx_valid    (rx_valid),
    .rx_code     (rx_code),
    .rx_tag      (rx_tag),
    .rx_addr     (rx_addr),
    .rx_len      (rx_len),
    .rx_frame_err(rx_frame_err)
  );

endmodule

// File: rtl/cmd_link_chk.sv
module cmd_link_chk #(
  parameter int CODE_W = 5,
  parameter int TAG_W  = 5,
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [CODE_W-1:0] in_code,
  input logic [TAG_W-1:0]  in_tag,
  input logic              tx_line,
  input logic              rx_valid,
  input logic [CODE_W-1:0] rx_code,
  input logic [TAG_W-1:0]  rx_tag,
  input logic [ADDR_W-1:0] rx_addr,
  input logic [LEN_W-1:0]  rx_len,
  input logic              rx_frame_err
);

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> tx_line);

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!tx_line && !in_ready));

  assert_marker_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ##1 tx_line);

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> (in_valid && $stable(in_code) && $stable(in_tag)));

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_fields_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable({rx_code, rx_tag, rx_addr, rx_len}));

  assert_err_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame_err |=> !rx_frame_err);

  assert_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_frame_err && rx_valid));

endmodule

bind cmd_link cmd_link_chk #(
  .CODE_W(CODE_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_code     (in_code),
  .in_tag      (in_tag),
  .tx_line     (tx_line),
  .rx_valid    (rx_valid),
  .rx_code     (rx_code),
  .rx_tag      (rx_tag),
  .rx_addr     (rx_addr),
  .rx_len      (rx_len),
  .rx_frame_err(rx_frame_err)
);

// File: tb/cmd_link_tb.sv
module cmd_link_tb;

  localparam int CW = 5, TW = 5, AW = 8, LW = 3;
  localparam int FL_BAS = 2 + CW + TW;
  localparam int FL_EXT = FL_BAS + AW + LW;

  typedef struct packed {
    logic          lat_chk;
    logic          ext;
    logic [CW-1:0] code;
    logic [TW-1:0] tag;
    logic [AW-1:0] addr;
    logic [LW-1:0] len;
    int            acc;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ext = 1'b0, rx_ext = 1'b0;
  logic [CW-1:0] in_code = '0;
  logic [TW-1:0] in_tag = '0;
  logic [AW-1:0] in_addr = '0;
  logic [LW-1:0] in_len = '0;
  logic in_ready, tx_line, rx_line, rx_valid, rx_frame_err;
  logic [CW-1:0] rx_code;
  logic [TW-1:0] rx_tag;
  logic [AW-1:0] rx_addr;
  logic [LW-1:0] rx_len;
  logic force_on = 1'b0, force_val = 1'b1;
  logic expect_err = 1'b0;
  int   cyc = 0;
  int   n_tests = 0, n_fail = 0;
  bit   done = 1'b0;
  exp_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign rx_line = force_on ? force_val : tx_line;

  cmd_link #(.CODE_W(CW), .TAG_W(TW), .ADDR_W(AW), .LEN_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ext(in_ext), .in_code(in_code), .in_tag(in_tag), .in_addr(in_addr),
    .in_len(in_len), .tx_line(tx_line), .rx_line(rx_line), .rx_ext(rx_ext),
    .rx_valid(rx_valid), .rx_code(rx_code), .rx_tag(rx_tag), .rx_addr(rx_addr),
    .rx_len(rx_len), .rx_frame_err(rx_frame_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] build(input bit ext, input logic [CW-1:0] c,
      input logic [TW-1:0] t, input logic [AW-1:0] a, input logic [LW-1:0] l);
    logic [31:0] f;
    f = {20'b0, 2'b01, c, t};
    if (ext) f = (f << (AW + LW)) | {21'b0, a, l};
    return f;
  endfunction

  // receiver monitor: R6/R7 fields and latency, R8/R9 stray pulses
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rx_valid) begin
        if (q.size() == 0) begin
          check(1'b0, "R9", "strobe with nothing sent", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(rx_code == e.code, "R6", "rx_code", rx_code, e.code);
          check(rx_tag == e.tag, "R6", "rx_tag", rx_tag, e.tag);
          check(rx_addr == e.addr, e.ext ? "R6" : "R7", "rx_addr", rx_addr, e.addr);
          check(rx_len == e.len, e.ext ? "R6" : "R7", "rx_len", rx_len, e.len);
          if (e.lat_chk)
            check(cyc == e.acc + (e.ext ? FL_EXT : FL_BAS), "R6", "strobe cycle",
                  cyc, e.acc + (e.ext ? FL_EXT : FL_BAS));
        end
      end
      if (rx_frame_err && !expect_err)
        check(1'b0, "R8", "unexpected frame error", 1, 0);
    end
  end

  // called at a negedge; returns at the negedge after the last bit
  task automatic send(input bit ext, input logic [CW-1:0] c, input logic [TW-1:0] t,
                      input logic [AW-1:0] a, input logic [LW-1:0] l);
    int fl;
    logic [31:0] fr;
    exp_t e;
    fl = ext ? FL_EXT : FL_BAS;
    fr = build(ext, c, t, a, l);
    in_valid = 1'b1; in_ext = ext; in_code = c; in_tag = t; in_addr = a; in_len = l;
    rx_ext = ext;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    e.lat_chk = 1'b1; e.ext = ext; e.code = c; e.tag = t;
    e.addr = ext ? a : '0; e.len = ext ? l : '0; e.acc = cyc;
    q.push_back(e);
    for (int k = 0; k < fl; k++) begin
      check(tx_line == fr[fl-1-k], ext ? "R3" : "R2", "line bit", tx_line, fr[fl-1-k]);
      check(!in_ready, "R4", "ready during frame", in_ready, 0);
      @(negedge clk);
    end
    check(in_ready && tx_line, "R5", "ready after last bit", {in_ready, tx_line}, 2'b11);
  endtask

  task automatic drive_bit(input logic b);
    force_val = b;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    check(tx_line == 1'b1, "R1", "tx_line after reset", tx_line, 1);
    check(!rx_valid && !rx_frame_err, "R1", "rx outputs after reset",
          {rx_valid, rx_frame_err}, 0);

    // directed corners
    send(1'b0, '0, '0, '0, '0);
    send(1'b0, '1, '1, '0, '0);
    send(1'b1, '1, '1, '1, '1);
    send(1'b1, 5'h10, 5'h01, 8'h80, 3'b001);
    send(1'b0, 5'h15, 5'h0A, 8'hFF, 3'h7);   // R7: extra fields dropped in basic mode

    // constrained random, gaps 0..2 idle cycles (gap 0 is back-to-back, R5)
    for (int i = 0; i < 60; i++) begin
      int gap;
      gap = $urandom % 3;
      repeat (gap) @(negedge clk);
      send(1'($urandom % 2), CW'($urandom), TW'($urandom), AW'($urandom), LW'($urandom));
    end
    repeat (3) @(negedge clk);

    // R9: a quiet high line
    force_on = 1'b1; force_val = 1'b1;
    repeat (5) @(negedge clk);
    check(!rx_valid && !rx_frame_err, "R9", "idle line quiet", {rx_valid, rx_frame_err}, 0);

    // R8: start bit followed by 0
    expect_err = 1'b1;
    drive_bit(1'b0);
    drive_bit(1'b0);
    check(rx_frame_err == 1'b1, "R8", "frame error pulse", rx_frame_err, 1);
    check(rx_valid == 1'b0, "R8", "no strobe on bad marker", rx_valid, 0);
    force_val = 1'b1;
    @(negedge clk);
    check(rx_frame_err == 1'b0, "R8", "error pulse one cycle", rx_frame_err, 0);
    expect_err = 1'b0;
    repeat (2) @(negedge clk);

    // R8: recovery with a hand-driven basic frame after the error
    begin
      exp_t e;
      logic [31:0] fr;
      rx_ext = 1'b0;
      fr = build(1'b0, 5'h13, 5'h0A, '0, '0);
      e.lat_chk = 1'b0; e.ext = 1'b0; e.code = 5'h13; e.tag = 5'h0A;
      e.addr = '0; e.len = '0; e.acc = 0;
      q.push_back(e);
      for (int k = FL_BAS - 1; k >= 0; k--) drive_bit(fr[k]);
      force_val = 1'b1;
      repeat (3) @(negedge clk);
      check(q.size() == 0, "R8", "frame after error received", q.size(), 0);
    end
    force_on = 1'b0;
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R6", "all commands received", q.size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule